// File: doc/BRIEF.md
# ATA Task-File Register Interface

This block is the host-facing register file of an ATA/IDE device. The host makes one access per cycle through a simple port: direction, block select (command or control), a 3-bit offset, a byte count and 32 bits of write data. The block decodes the access, keeps the byte-wide task-file registers and the device control state, and returns read data one cycle later.

Accesses have side effects, and a separate device state machine needs to see them. For this the block raises single-cycle event strobes when a data word moves, when status is read, when a drive is selected, when a command is written, and when soft reset is entered or left. The block does not buffer data. Each 16-bit word passes straight between the host port and the device side. A 32-bit access is split into two words on consecutive cycles, and the port stalls for one cycle while the second word moves.

The block also holds the interrupt-disable bit and an interrupt-pending flag. From these it produces the interrupt request. It also sets a sticky interrupt bit for the bus-master status logic. Command execution, sector storage and DMA sit outside the block.

Top module: `taskfile_regs`

## Requirements
- R1: After reset, all six stored registers, `nien`, `srst_active`, `intrq`, `bm_intr`, `rd_valid` and every event strobe are 0, and `acc_ready` is 1.
- R2: An accepted access to command offset 0 with byte count 2 raises `ev_data` in that cycle for one word. A write drives `xfer_wdata` = `acc_wdata[15:0]` with `ev_data_wr`=1. A read returns `{16'h0, xfer_rdata}` on `rd_data` with `rd_valid` in the next cycle.
- R3: An accepted data access with byte count 4 raises `ev_data` in the accept cycle (low half, `acc_wdata[15:0]`) and again in the next cycle (high half, `acc_wdata[31:16]`), with `acc_ready`=0 in that second cycle. A read returns `{second word, first word}` one cycle after the second half.
- R4: A data-port access whose byte count is neither 2 nor 4 raises `acc_err`, with no `ev_data` and no `rd_valid`.
- R5: Command offsets 1..7 accept only byte count 1. Any other count raises `acc_err` and changes no register.
- R6: Byte writes to command offsets 2, 3, 4 and 5 store into `sec_count`, `sec_num`, `cyl_lo` and `cyl_hi`. Byte reads of offsets 2..6 return the stored byte, and a byte read of offset 1 returns `dev_error`.
- R7: A byte read of command offset 7 returns `dev_status`, raises `ev_stat_rd` and clears the pending flag. A byte read of control offset 2 returns `dev_status` with no event and leaves the pending flag set.
- R8: A byte write to command offset 1 changes no register and raises no event and no error.
- R9: A byte write to offset 6 stores `drv_head` and raises `ev_select`. A byte write to offset 7 stores `command` and raises `ev_cmd`.
- R10: A byte write to control offset 2 with bit 2 set raises `ev_srst_set` and sets `srst_active`. The same write with bit 2 clear raises `ev_srst_clr` and clears `srst_active` only if `srst_active` was 1; otherwise it raises nothing.
- R11: Every byte write to control offset 2 loads `nien` from bit 1.
- R12: `dev_intr_post` sets the pending flag and `bm_intr` in the next cycle. `intrq` is the pending flag while `nien` is 0. `bm_intr` is cleared only by `bm_intr_clr`. A post wins over a clear or a status read in the same cycle.
- R13: A control-block access to any offset other than 2, or with a byte count other than 1, raises `acc_err` and changes no state.
- R14: An access presented while `acc_ready` is 0 is not accepted: it raises no event and no error and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Host access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_ctrl | input | 1 | 1 = control block, 0 = command block |
| acc_offset | input | 3 | Register offset in the selected block |
| acc_size | input | 3 | Access size in bytes (1, 2 or 4 legal where allowed) |
| acc_wdata | input | 32 | Host write data |
| acc_ready | output | 1 | Low while the second half of a 32-bit data access moves |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| acc_err | output | 1 | Illegal access strobe |
| ev_data | output | 1 | One data word moves this cycle |
| ev_data_wr | output | 1 | Direction of that word, 1 = host write |
| xfer_wdata | output | 16 | Word written by the host |
| xfer_rdata | input | 16 | Word supplied by the device for a read |
| ev_stat_rd | output | 1 | Status register read strobe |
| ev_select | output | 1 | Drive/head write strobe |
| ev_cmd | output | 1 | Command write strobe |
| ev_srst_set | output | 1 | Soft reset asserted strobe |
| ev_srst_clr | output | 1 | Soft reset released strobe |
| dev_status | input | 8 | Device status byte |
| dev_error | input | 8 | Device error byte |
| dev_intr_post | input | 1 | Device posts an interrupt |
| bm_intr_clr | input | 1 | Clears the bus-master interrupt bit |
| intrq | output | 1 | Interrupt request |
| bm_intr | output | 1 | Bus-master status interrupt bit |
| sec_count | output | 8 | Sector count register |
| sec_num | output | 8 | Sector number register |
| cyl_lo | output | 8 | Cylinder low register |
| cyl_hi | output | 8 | Cylinder high register |
| drv_head | output | 8 | Drive/head register |
| command | output | 8 | Command register |
| nien | output | 1 | Interrupt disable |
| srst_active | output | 1 | Device held in soft reset |

## Verification
The event strobes, `acc_err`, `acc_ready` and `xfer_wdata` depend on the access itself. They are due in the same cycle that the access is presented. For a 32-bit access, the second `ev_data` is due exactly one cycle later. Read data, stored registers, `nien`, `srst_active`, the pending flag, `intrq` and `bm_intr` come from registers. They are due one cycle after the access or post that changes them, and a 32-bit read result is due one cycle after its second half. The bench drives inputs on the falling edge and compares against its reference model 1 ns later, every cycle. That sampling point observes same-cycle strobes while the access is presented, and registered results only after the rising edge that loads them.

// File: rtl/tf_pkg.sv
package tf_pkg;

    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 16;
    localparam int BUS_W    = 2 * WORD_W;
    localparam int OFF_W    = 3;
    localparam int SIZE_W   = 3;

    // command block offsets
    localparam logic [OFF_W-1:0] OFF_DATA    = 3'd0;
    localparam logic [OFF_W-1:0] OFF_ERRFEAT = 3'd1;
    localparam logic [OFF_W-1:0] OFF_DRIVE   = 3'd6;
    localparam logic [OFF_W-1:0] OFF_STATCMD = 3'd7;
    // control block offset
    localparam logic [OFF_W-1:0] OFF_CTL     = 3'd2;

    // byte registers that hold state: offsets 2..7
    localparam int REG_FIRST = 2;
    localparam int REG_LAST  = 7;
    localparam int NUM_REGS  = REG_LAST - REG_FIRST + 1;

    localparam logic [SIZE_W-1:0] SZ_BYTE  = 3'd1;
    localparam logic [SIZE_W-1:0] SZ_WORD  = 3'd2;
    localparam logic [SIZE_W-1:0] SZ_DWORD = 3'd4;

    // device control byte bit positions
    localparam int SRST_BIT = 2;
    localparam int NIEN_BIT = 1;

    typedef enum logic [3:0] {
        ACT_NONE,
        ACT_ERR,
        ACT_DATA,
        ACT_RD_REG,
        ACT_RD_STATUS,
        ACT_RD_ALT,
        ACT_WR_FEAT,
        ACT_WR_REG,
        ACT_WR_DRIVE,
        ACT_WR_CMD,
        ACT_WR_CTRL
    } act_e;

    typedef struct packed {
        act_e             act;
        logic             wide;
        logic [OFF_W-1:0] off;
    } dec_t;

    function automatic logic is_store(act_e a);
        return (a == ACT_WR_REG) || (a == ACT_WR_DRIVE) || (a == ACT_WR_CMD);
    endfunction

endpackage

// File: rtl/tf_decode.sv
module tf_decode
    import tf_pkg::*;
(
    input  logic              valid,
    input  logic              write,
    input  logic              ctrl,
    input  logic [OFF_W-1:0]  off,
    input  logic [SIZE_W-1:0] size,
    output dec_t              dec
);
    always_comb begin
        dec.act  = ACT_NONE;
        dec.wide = 1'b0;
        dec.off  = off;
        if (valid) begin
            if (ctrl) begin
                if (off != OFF_CTL || size != SZ_BYTE)
                    dec.act = ACT_ERR;
                else
                    dec.act = write ? ACT_WR_CTRL : ACT_RD_ALT;
            end else if (off == OFF_DATA) begin
                if (size == SZ_WORD || size == SZ_DWORD) begin
                    dec.act  = ACT_DATA;
                    dec.wide = (size == SZ_DWORD);
                end else begin
                    dec.act = ACT_ERR;
                end
            end else if (size != SZ_BYTE) begin
                dec.act = ACT_ERR;
            end else if (write) begin
                unique case (off)
                    OFF_ERRFEAT: dec.act = ACT_WR_FEAT;
                    OFF_DRIVE:   dec.act = ACT_WR_DRIVE;
                    OFF_STATCMD: dec.act = ACT_WR_CMD;
                    default:     dec.act = ACT_WR_REG;
                endcase
            end else begin
                dec.act = (off == OFF_STATCMD) ? ACT_RD_STATUS : ACT_RD_REG;
            end
        end
    end
endmodule

// File: rtl/tf_dataport.sv
module tf_dataport
    import tf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_wr,
    input  logic              start_wide,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [WORD_W-1:0] rdata,
    output logic              busy,
    output logic              xfer,
    output logic              xfer_wr,
    output logic [WORD_W-1:0] xfer_wdata,
    output logic              rd_fire,
    output logic [BUS_W-1:0]  rd_word
);
    logic              phase2_q;
    logic              ph_wr_q;
    logic [WORD_W-1:0] hi_q;
    logic [WORD_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase2_q <= 1'b0;
            ph_wr_q  <= 1'b0;
            hi_q     <= '0;
            lo_q     <= '0;
        end else begin
            phase2_q <= start & start_wide;
            if (start & start_wide) begin
                ph_wr_q <= start_wr;
                hi_q    <= wdata[BUS_W-1:WORD_W];
                lo_q    <= rdata;
            end
        end
    end

    assign busy       = phase2_q;
    assign xfer       = start | phase2_q;
    assign xfer_wr    = phase2_q ? ph_wr_q : start_wr;
    assign xfer_wdata = phase2_q ? hi_q : wdata[WORD_W-1:0];
    assign rd_fire    = (start & ~start_wr & ~start_wide) | (phase2_q & ~ph_wr_q);
    assign rd_word    = phase2_q ? {rdata, lo_q} : {{(BUS_W-WORD_W){1'b0}}, rdata};
endmodule

// File: rtl/tf_irq_ctl.sv
module tf_irq_ctl (
    input  logic clk,
    input  logic rst,
    input  logic ctrl_wr,
    input  logic srst_req,
    input  logic nien_val,
    input  logic stat_rd,
    input  logic intr_post,
    input  logic bm_clr,
    output logic nien,
    output logic srst,
    output logic ev_set,
    output logic ev_clr,
    output logic intrq,
    output logic bm_intr
);
    logic pend_q;

    assign ev_set = ctrl_wr & srst_req;
    assign ev_clr = ctrl_wr & ~srst_req & srst;

    always_ff @(posedge clk) begin
        if (rst) begin
            nien    <= 1'b0;
            srst    <= 1'b0;
            pend_q  <= 1'b0;
            bm_intr <= 1'b0;
        end else begin
            if (ctrl_wr) nien <= nien_val;
            if (ev_set)      srst <= 1'b1;
            else if (ev_clr) srst <= 1'b0;
            if (intr_post)    pend_q <= 1'b1;
            else if (stat_rd) pend_q <= 1'b0;
            if (intr_post)   bm_intr <= 1'b1;
            else if (bm_clr) bm_intr <= 1'b0;
        end
    end

    assign intrq = pend_q & ~nien;
endmodule

// File: rtl/taskfile_regs.sv
module taskfile_regs
    import tf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_ctrl,
    input  logic [OFF_W-1:0]  acc_offset,
    input  logic [SIZE_W-1:0] acc_size,
    input  logic [BUS_W-1:0]  acc_wdata,
    output logic              acc_ready,
    output logic              rd_valid,
    output logic [BUS_W-1:0]  rd_data,
    output logic              acc_err,
    output logic              ev_data,
    output logic              ev_data_wr,
    output logic [WORD_W-1:0] xfer_wdata,
    input  logic [WORD_W-1:0] xfer_rdata,
    output logic              ev_stat_rd,
    output logic              ev_select,
    output logic              ev_cmd,
    output logic              ev_srst_set,
    output logic              ev_srst_clr,
    input  logic [BYTE_W-1:0] dev_status,
    input  logic [BYTE_W-1:0] dev_error,
    input  logic              dev_intr_post,
    input  logic              bm_intr_clr,
    output logic              intrq,
    output logic              bm_intr,
    output logic [BYTE_W-1:0] sec_count,
    output logic [BYTE_W-1:0] sec_num,
    output logic [BYTE_W-1:0] cyl_lo,
    output logic [BYTE_W-1:0] cyl_hi,
    output logic [BYTE_W-1:0] drv_head,
    output logic [BYTE_W-1:0] command,
    output logic              nien,
    output logic              srst_active
);
    logic accept;
    dec_t dec;

    assign accept = acc_valid & acc_ready;

    tf_decode u_dec (
        .valid (accept),
        .write (acc_write),
        .ctrl  (acc_ctrl),
        .off   (acc_offset),
        .size  (acc_size),
        .dec   (dec)
    );

    // data port: word pass-through with 32-bit split
    logic             dp_busy;
    logic             dp_rd_fire;
    logic [BUS_W-1:0] dp_rd_word;

    tf_dataport u_dp (
        .clk        (clk),
        .rst        (rst),
        .start      (dec.act == ACT_DATA),
        .start_wr   (acc_write),
        .start_wide (dec.wide),
        .wdata      (acc_wdata),
        .rdata      (xfer_rdata),
        .busy       (dp_busy),
        .xfer       (ev_data),
        .xfer_wr    (ev_data_wr),
        .xfer_wdata (xfer_wdata),
        .rd_fire    (dp_rd_fire),
        .rd_word    (dp_rd_word)
    );

    assign acc_ready = ~dp_busy;

    // device control, soft reset and interrupt state
    tf_irq_ctl u_irq (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (dec.act == ACT_WR_CTRL),
        .srst_req  (acc_wdata[SRST_BIT]),
        .nien_val  (acc_wdata[NIEN_BIT]),
        .stat_rd   (ev_stat_rd),
        .intr_post (dev_intr_post),
        .bm_clr    (bm_intr_clr),
        .nien      (nien),
        .srst      (srst_active),
        .ev_set    (ev_srst_set),
        .ev_clr    (ev_srst_clr),
        .intrq     (intrq),
        .bm_intr   (bm_intr)
    );

    assign ev_stat_rd = (dec.act == ACT_RD_STATUS);
    assign ev_select  = (dec.act == ACT_WR_DRIVE);
    assign ev_cmd     = (dec.act == ACT_WR_CMD);
    assign acc_err    = (dec.act == ACT_ERR);

    // byte-wide task-file storage, offsets REG_FIRST..REG_LAST
    logic [BYTE_W-1:0] tf_q [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [OFF_W-1:0] MY_OFF = OFF_W'(i + REG_FIRST);
        always_ff @(posedge clk) begin
            if (rst)
                tf_q[i] <= '0;
            else if (is_store(dec.act) && dec.off == MY_OFF)
                tf_q[i] <= acc_wdata[BYTE_W-1:0];
        end
    end

    assign sec_count = tf_q[0];
    assign sec_num   = tf_q[1];
    assign cyl_lo    = tf_q[2];
    assign cyl_hi    = tf_q[3];
    assign drv_head  = tf_q[4];
    assign command   = tf_q[5];

    // byte read path
    logic              byte_fire;
    logic [BYTE_W-1:0] byte_val;

    always_comb begin
        byte_fire = 1'b1;
        byte_val  = '0;
        unique case (dec.act)
            ACT_RD_STATUS, ACT_RD_ALT: byte_val = dev_status;
            ACT_RD_REG: begin
                if (dec.off == OFF_ERRFEAT) byte_val = dev_error;
                for (int i = 0; i < NUM_REGS; i++)
                    if (dec.off == OFF_W'(i + REG_FIRST)) byte_val = tf_q[i];
            end
            default: byte_fire = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= byte_fire | dp_rd_fire;
            if (dp_rd_fire)
                rd_data <= dp_rd_word;
            else if (byte_fire)
                rd_data <= {{(BUS_W-BYTE_W){1'b0}}, byte_val};
        end
    end
endmodule

// File: rtl/tf_checker.sv
module tf_checker (
    input logic        clk,
    input logic        rst,
    input logic        acc_valid,
    input logic        acc_write,
    input logic        acc_ctrl,
    input logic [2:0]  acc_offset,
    input logic [2:0]  acc_size,
    input logic        acc_ready,
    input logic        acc_err,
    input logic        ev_data,
    input logic        ev_stat_rd,
    input logic        ev_select,
    input logic        ev_cmd,
    input logic        ev_srst_set,
    input logic        ev_srst_clr,
    input logic        dev_intr_post,
    input logic        intrq,
    input logic        bm_intr,
    input logic [7:0]  sec_count,
    input logic [7:0]  sec_num,
    input logic [7:0]  cyl_lo,
    input logic [7:0]  cyl_hi,
    input logic [7:0]  drv_head,
    input logic [7:0]  command,
    input logic        nien,
    input logic        srst_active
);
    logic acc_ok;
    assign acc_ok = acc_valid && acc_ready;

    a_r3_second_half: assert property (@(posedge clk) disable iff (rst)
        (acc_ok && !acc_ctrl && acc_offset == 3'd0 && acc_size == 3'd4)
        |=> (ev_data && !acc_ready));

    a_r14_stall_one_cycle: assert property (@(posedge clk) disable iff (rst)
        !acc_ready |=> acc_ready);

    a_r12_intrq_gated: assert property (@(posedge clk) disable iff (rst)
        intrq |-> !nien);

    a_r12_post_sets_bm: assert property (@(posedge clk) disable iff (rst)
        dev_intr_post |=> bm_intr);

    a_r9_single_event: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_stat_rd, ev_select, ev_cmd, ev_srst_set, ev_srst_clr, acc_err}));

    a_r10_enter_reset: assert property (@(posedge clk) disable iff (rst)
        ev_srst_set |=> srst_active);

    a_r10_leave_reset: assert property (@(posedge clk) disable iff (rst)
        ev_srst_clr |=> !srst_active);

    a_r7_alt_quiet: assert property (@(posedge clk) disable iff (rst)
        (acc_ok && acc_ctrl && !acc_write) |-> !ev_stat_rd);

    a_r4_err_no_data: assert property (@(posedge clk) disable iff (rst)
        (acc_err && acc_ready) |-> !ev_data);

    a_r13_err_no_change: assert property (@(posedge clk) disable iff (rst)
        acc_err |=> ($stable(sec_count) && $stable(sec_num) && $stable(cyl_lo)
                     && $stable(cyl_hi) && $stable(drv_head) && $stable(command)
                     && $stable(nien) && $stable(srst_active)));
endmodule

bind taskfile_regs tf_checker i_tf_checker (
    .clk           (clk),
    .rst           (rst),
    .acc_valid     (acc_valid),
    .acc_write     (acc_write),
    .acc_ctrl      (acc_ctrl),
    .acc_offset    (acc_offset),
    .acc_size      (acc_size),
    .acc_ready     (acc_ready),
    .acc_err       (acc_err),
    .ev_data       (ev_data),
    .ev_stat_rd    (ev_stat_rd),
    .ev_select     (ev_select),
    .ev_cmd        (ev_cmd),
    .ev_srst_set   (ev_srst_set),
    .ev_srst_clr   (ev_srst_clr),
    .dev_intr_post (dev_intr_post),
    .intrq         (intrq),
    .bm_intr       (bm_intr),
    .sec_count     (sec_count),
    .sec_num       (sec_num),
    .cyl_lo        (cyl_lo),
    .cyl_hi        (cyl_hi),
    .drv_head      (drv_head),
    .command       (command),
    .nien          (nien),
    .srst_active   (srst_active)
);

// File: tb/test_taskfile_regs.sv
`timescale 1ns/1ps
module test_taskfile_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_ctrl = 1'b0;
    logic [2:0]  acc_offset = '0, acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic        acc_ready, rd_valid, acc_err, ev_data, ev_data_wr;
    logic [31:0] rd_data;
    logic [15:0] xfer_wdata;
    logic [15:0] xfer_rdata = 16'h1000;
    logic        ev_stat_rd, ev_select, ev_cmd, ev_srst_set, ev_srst_clr;
    logic [7:0]  dev_status = 8'h50, dev_error = 8'h04;
    logic        dev_intr_post = 1'b0, bm_intr_clr = 1'b0;
    logic        intrq, bm_intr, nien, srst_active;
    logic [7:0]  sec_count, sec_num, cyl_lo, cyl_hi, drv_head, command;

    always #2 clk = ~clk;

    taskfile_regs i_taskfile_regs (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_ctrl(acc_ctrl), .acc_offset(acc_offset), .acc_size(acc_size),
        .acc_wdata(acc_wdata), .acc_ready(acc_ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .acc_err(acc_err), .ev_data(ev_data),
        .ev_data_wr(ev_data_wr), .xfer_wdata(xfer_wdata), .xfer_rdata(xfer_rdata),
        .ev_stat_rd(ev_stat_rd), .ev_select(ev_select), .ev_cmd(ev_cmd),
        .ev_srst_set(ev_srst_set), .ev_srst_clr(ev_srst_clr),
        .dev_status(dev_status), .dev_error(dev_error),
        .dev_intr_post(dev_intr_post), .bm_intr_clr(bm_intr_clr),
        .intrq(intrq), .bm_intr(bm_intr), .sec_count(sec_count),
        .sec_num(sec_num), .cyl_lo(cyl_lo), .cyl_hi(cyl_hi),
        .drv_head(drv_head), .command(command), .nien(nien),
        .srst_active(srst_active)
    );

    int    checks = 0;
    int    bad = 0;
    bit    done = 0;
    string tag = "R1";

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // ---------------- reference model state ----------------
    logic [7:0]  m_reg [8];
    logic [7:0]  n_reg [8];
    logic        m_nien, m_srst, m_pend, m_bm, m_ph2, m_phwr, m_rdv;
    logic        n_nien, n_srst, n_pend, n_bm, n_ph2, n_phwr, n_rdv;
    logic [15:0] m_hi, m_lo, n_hi, n_lo;
    logic [31:0] m_rdd, n_rdd;
    logic [15:0] dev_word = 16'h1000;
    bit          adv = 0;

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
        m_nien = 0; m_srst = 0; m_pend = 0; m_bm = 0;
        m_ph2 = 0; m_phwr = 0; m_rdv = 0;
        m_hi = '0; m_lo = '0; m_rdd = '0;
    endtask

    task automatic model_commit();
        for (int i = 0; i < 8; i++) m_reg[i] = n_reg[i];
        m_nien = n_nien; m_srst = n_srst; m_pend = n_pend; m_bm = n_bm;
        m_ph2 = n_ph2; m_phwr = n_phwr; m_rdv = n_rdv;
        m_hi = n_hi; m_lo = n_lo; m_rdd = n_rdd;
    endtask

    task automatic evaluate();
        logic e_data, e_dir, e_err, e_st, e_sel, e_cmd, e_set, e_clr, acc;
        logic [15:0] e_wd;
        e_data = 0; e_dir = 0; e_err = 0; e_st = 0; e_sel = 0;
        e_cmd = 0; e_set = 0; e_clr = 0; e_wd = '0;
        for (int i = 0; i < 8; i++) n_reg[i] = m_reg[i];
        n_nien = m_nien; n_srst = m_srst; n_pend = m_pend; n_bm = m_bm;
        n_ph2 = 0; n_phwr = m_phwr; n_rdv = 0; n_rdd = m_rdd;
        n_hi = m_hi; n_lo = m_lo;
        acc = acc_valid && !m_ph2;
        if (m_ph2) begin
            e_data = 1; e_dir = m_phwr; e_wd = m_hi;
            if (!m_phwr) begin
                n_rdv = 1; n_rdd = {xfer_rdata, m_lo}; adv = 1;
            end
        end
        if (acc) begin
            if (acc_ctrl) begin
                if (acc_offset != 3'd2 || acc_size != 3'd1) e_err = 1;
                else if (acc_write) begin
                    if (acc_wdata[2]) begin e_set = 1; n_srst = 1; end
                    else if (m_srst) begin e_clr = 1; n_srst = 0; end
                    n_nien = acc_wdata[1];
                end else begin
                    n_rdv = 1; n_rdd = {24'h0, dev_status};
                end
            end else if (acc_offset == 3'd0) begin
                if (acc_size == 3'd2 || acc_size == 3'd4) begin
                    e_data = 1; e_dir = acc_write; e_wd = acc_wdata[15:0];
                    if (!acc_write) begin
                        adv = 1;
                        if (acc_size == 3'd2) begin n_rdv = 1; n_rdd = {16'h0, xfer_rdata}; end
                        else n_lo = xfer_rdata;
                    end
                    if (acc_size == 3'd4) begin
                        n_ph2 = 1; n_phwr = acc_write; n_hi = acc_wdata[31:16];
                    end
                end else e_err = 1;
            end else if (acc_size != 3'd1) begin
                e_err = 1;
            end else if (acc_write) begin
                if (acc_offset != 3'd1) n_reg[acc_offset] = acc_wdata[7:0];
                if (acc_offset == 3'd6) e_sel = 1;
                if (acc_offset == 3'd7) e_cmd = 1;
            end else begin
                n_rdv = 1;
                if (acc_offset == 3'd1) n_rdd = {24'h0, dev_error};
                else if (acc_offset == 3'd7) begin n_rdd = {24'h0, dev_status}; e_st = 1; end
                else n_rdd = {24'h0, m_reg[acc_offset]};
            end
        end
        if (dev_intr_post) n_pend = 1; else if (e_st) n_pend = 0;
        if (dev_intr_post) n_bm = 1; else if (bm_intr_clr) n_bm = 0;

        chk("acc_ready", acc_ready, !m_ph2);
        chk("ev_data", ev_data, e_data);
        if (e_data) chk("ev_data_wr", ev_data_wr, e_dir);
        if (e_data && e_dir) chk("xfer_wdata", xfer_wdata, e_wd);
        chk("acc_err", acc_err, e_err);
        chk("ev_stat_rd", ev_stat_rd, e_st);
        chk("ev_select", ev_select, e_sel);
        chk("ev_cmd", ev_cmd, e_cmd);
        chk("ev_srst_set", ev_srst_set, e_set);
        chk("ev_srst_clr", ev_srst_clr, e_clr);
        chk("rd_valid", rd_valid, m_rdv);
        if (m_rdv) chk("rd_data", rd_data, m_rdd);
        chk("sec_count", sec_count, m_reg[2]);
        chk("sec_num", sec_num, m_reg[3]);
        chk("cyl_lo", cyl_lo, m_reg[4]);
        chk("cyl_hi", cyl_hi, m_reg[5]);
        chk("drv_head", drv_head, m_reg[6]);
        chk("command", command, m_reg[7]);
        chk("nien", nien, m_nien);
        chk("srst_active", srst_active, m_srst);
        chk("intrq", intrq, m_pend & !m_nien);
        chk("bm_intr", bm_intr, m_bm);
    endtask

    // per-cycle compare: inputs change on the falling edge, compare 1 ns later
    initial begin
        model_reset();
        forever begin
            @(negedge clk);
            if (adv) begin dev_word = dev_word + 16'h1111; adv = 0; end
            xfer_rdata = dev_word;
            #1;
            if (!rst) evaluate();
            @(posedge clk);
            if (rst) model_reset(); else model_commit();
        end
    end

    // ---------------- stimulus ----------------
    task automatic access(bit wr, bit ctl, logic [2:0] off, logic [2:0] sz, logic [31:0] wd);
        @(negedge clk);
        acc_valid = 1; acc_write = wr; acc_ctrl = ctl;
        acc_offset = off; acc_size = sz; acc_wdata = wd;
        dev_intr_post = 0; bm_intr_clr = 0;
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            acc_valid = 0; dev_intr_post = 0; bm_intr_clr = 0;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1: reset state seen at the ports
        tag = "R1";
        chk("R1 ready", acc_ready, 1'b1);
        chk("R1 regs", {sec_count, sec_num, cyl_lo, cyl_hi}, 32'h0);
        chk("R1 drv/cmd", {drv_head, command}, 32'h0);
        chk("R1 flags", {nien, srst_active, intrq, bm_intr, rd_valid}, 32'h0);

        tag = "R6";
        access(1, 0, 3'd2, 3'd1, 32'h11);
        access(1, 0, 3'd3, 3'd1, 32'h22);
        access(1, 0, 3'd4, 3'd1, 32'h33);
        access(1, 0, 3'd5, 3'd1, 32'hFFFF_FF44);
        access(0, 0, 3'd2, 3'd1, 0);
        access(0, 0, 3'd5, 3'd1, 0);
        access(0, 0, 3'd1, 3'd1, 0);
        idle(1);

        tag = "R9";
        access(1, 0, 3'd6, 3'd1, 32'hA0);
        access(1, 0, 3'd7, 3'd1, 32'hEC);
        access(0, 0, 3'd6, 3'd1, 0);
        idle(1);

        tag = "R8";
        access(1, 0, 3'd1, 3'd1, 32'hFF);
        idle(1);

        tag = "R2";
        access(1, 0, 3'd0, 3'd2, 32'h5555_BEEF);
        access(0, 0, 3'd0, 3'd2, 0);
        access(0, 0, 3'd0, 3'd2, 0);
        idle(2);

        tag = "R3";
        access(1, 0, 3'd0, 3'd4, 32'hCAFE_1234);
        idle(1);
        access(0, 0, 3'd0, 3'd4, 0);
        idle(3);

        tag = "R14";
        access(1, 0, 3'd0, 3'd4, 32'h8765_4321);
        access(1, 0, 3'd2, 3'd1, 32'h77);
        idle(2);

        tag = "R4";
        access(1, 0, 3'd0, 3'd1, 32'h99);
        access(0, 0, 3'd0, 3'd3, 0);
        idle(1);

        tag = "R5";
        access(1, 0, 3'd3, 3'd2, 32'hEE);
        access(0, 0, 3'd7, 3'd4, 0);
        access(1, 0, 3'd7, 3'd2, 32'h20);
        idle(1);

        tag = "R13";
        access(1, 1, 3'd0, 3'd1, 32'h06);
        access(1, 1, 3'd2, 3'd2, 32'h06);
        access(0, 1, 3'd6, 3'd1, 0);
        idle(1);

        tag = "R10";
        access(1, 1, 3'd2, 3'd1, 32'h04);
        access(1, 1, 3'd2, 3'd1, 32'h04);
        access(1, 1, 3'd2, 3'd1, 32'h00);
        access(1, 1, 3'd2, 3'd1, 32'h00);
        idle(1);

        tag = "R11";
        access(1, 1, 3'd2, 3'd1, 32'h02);
        access(1, 1, 3'd2, 3'd1, 32'h06);
        access(1, 1, 3'd2, 3'd1, 32'h00);
        idle(1);

        tag = "R12";
        @(negedge clk); acc_valid = 0; dev_intr_post = 1;
        idle(2);
        tag = "R7";
        access(0, 1, 3'd2, 3'd1, 0);
        idle(1);
        access(0, 0, 3'd7, 3'd1, 0);
        idle(2);

        tag = "R12";
        access(1, 1, 3'd2, 3'd1, 32'h02);
        @(negedge clk); acc_valid = 0; dev_intr_post = 1;
        idle(1);
        access(1, 1, 3'd2, 3'd1, 32'h00);
        idle(1);
        @(negedge clk); acc_valid = 0; bm_intr_clr = 1;
        idle(1);
        @(negedge clk); acc_valid = 0; dev_intr_post = 1; bm_intr_clr = 1;
        idle(1);
        access(0, 0, 3'd7, 3'd1, 0);
        dev_intr_post = 1;
        idle(3);

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=completion");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule